// File: doc/BRIEF.md
# Serial Converter Command and Result Port

This block is the digital side of a two-channel, 12-bit successive-approximation converter as it appears on a three-wire serial port. A host lowers chip select, clocks in a start bit followed by a two-bit command, and then keeps clocking the serial clock to read the result back. The analog inputs are stood in for by two digital codes, one per channel. These are taken at the moment the sampling window closes.

The command chooses between two single-ended channels and one pseudo-differential pair, and says which channel is the positive input. A pseudo-differential result is the positive code minus the negative code, held at 000h when the difference is zero or negative and at FFFh when the difference reaches full scale. A sample-window flag marks the 1.5 serial-clock periods in which the input would be acquired. The serial pins are a fixed-timing pin protocol paced by the host's clock, so there is no valid/ready pair and no back-pressure. The host simply stops clocking, and the port waits with its state intact. `sclk`, `cs_n` and `din` are assumed to be synchronous to `clk` and to stay stable for at least two `clk` periods between changes.

Top module: `serial_adc_port`

## Requirements
- R1: While `cs_n` is high, `dout_en` is 0. One `clk` later, `dout` and `sample_win` are 0 as well. While `cs_n` is low, `dout_en` is 1.
- R2: After `cs_n` falls, the first `sclk` rising edge that samples `din` = 1 is taken as the start bit. Rising edges that sample 0 before it are ignored.
- R3: The next rising edge after the start bit samples the mode bit: 1 selects single-ended and 0 selects pseudo-differential. The rising edge after that samples the select bit.
- R4: `sample_win` rises after the second rising edge following the start bit. It falls after the falling edge that follows the third rising edge, so it stays high for 1.5 `sclk` periods.
- R5: On the falling edge that closes the window, `dout` drives a null bit of 0. The 12 result bits then follow, most significant first, one per following falling edge.
- R6: While `cs_n` stays low, `dout` changes only in response to a falling edge of `sclk`.
- R7: After the least significant bit, every further falling edge drives `dout` low until `cs_n` rises.
- R8: In single-ended mode, select 0 returns `ch0_code` and select 1 returns `ch1_code`. The value returned is the one present at the window-closing edge.
- R9: In pseudo-differential mode, select 0 makes channel 0 the positive input and select 1 makes channel 1 the positive input. The result is positive minus negative, or 000h when positive ≤ negative.
- R10: In pseudo-differential mode the result saturates at FFFh once the difference reaches 4095.
- R11: After a conversion, further start bits are ignored until `cs_n` has gone high and low again.
- R12: Raising `cs_n` at any point aborts the conversion, and the next transaction runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command input |
| ch0_code | input | 12 | Digital stand-in for channel 0 input level |
| ch1_code | input | 12 | Digital stand-in for channel 1 input level |
| dout | output | 1 | Serial result output |
| dout_en | output | 1 | Output drive enable (0 means high impedance) |
| sample_win | output | 1 | High during the acquisition window |

## Verification
Random commands with random channel codes and a random number of leading zero bits try both modes and both select values. A mismatch there separates a wrong channel choice from a swapped polarity or a misplaced start-bit detection. Directed pairs test equal codes, a negative difference, a full-scale difference and all-ones single-ended codes, which tell the lower clamp from the upper one. A second start sequence sent without releasing chip select, and a conversion aborted inside its sampling window, tell proper re-arming apart from a port that restarts on its own.

// File: rtl/serial_adc_pkg.sv
package serial_adc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MODE,
    ST_SEL,
    ST_SAMP_A,
    ST_SAMP_B,
    ST_XFER
  } port_state_t;
endpackage

// File: rtl/sclk_edge_det.sv
module sclk_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/adc_cmd_ctl.sv
module adc_cmd_ctl
  import serial_adc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rise,
  input  logic fall,
  input  logic din,
  output logic single_ended,
  output logic sel,
  output logic sample_win,
  output logic load
);
  port_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      single_ended <= 1'b0;
      sel          <= 1'b0;
    end else if (cs_n) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:   if (rise && din) st <= ST_MODE;
        ST_MODE:   if (rise) begin single_ended <= din; st <= ST_SEL; end
        ST_SEL:    if (rise) begin sel <= din; st <= ST_SAMP_A; end
        ST_SAMP_A: if (rise) st <= ST_SAMP_B;
        ST_SAMP_B: if (fall) st <= ST_XFER;
        ST_XFER:   st <= ST_XFER;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign sample_win = (st == ST_SAMP_A) || (st == ST_SAMP_B);
  assign load       = (st == ST_SAMP_B) && fall && !cs_n;

  assert_win_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_win) |-> $past(rise));
  assert_win_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sample_win) |-> ($past(fall) || $past(cs_n)));
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_XFER && !cs_n) |=> !sample_win);
  assert_idle_win_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sample_win);
endmodule

// File: rtl/adc_result_calc.sv
module adc_result_calc #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              single_ended,
  input  logic              sel,
  input  logic [DATA_W-1:0] ch0_code,
  input  logic [DATA_W-1:0] ch1_code,
  output logic [DATA_W-1:0] result
);
  localparam logic [DATA_W-1:0] FULL = {DATA_W{1'b1}};

  logic [DATA_W-1:0] pos, neg;
  logic [DATA_W:0]   diff;

  assign pos  = sel ? ch1_code : ch0_code;
  assign neg  = sel ? ch0_code : ch1_code;
  assign diff = {1'b0, pos} - {1'b0, neg};

  always_comb begin
    if (single_ended)             result = pos;
    else if (diff[DATA_W])        result = '0;
    else if (diff >= {1'b0, FULL}) result = FULL;
    else                          result = diff[DATA_W-1:0];
  end

  assert_diff_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !single_ended |-> (result <= pos));
endmodule

// File: rtl/adc_out_shifter.sv
module adc_out_shifter #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic              fall,
  input  logic [DATA_W-1:0] result,
  output logic              dout
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LEN = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sreg;
  logic [CNT_W-1:0]  left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      left <= '0;
      dout <= 1'b0;
    end else if (clear) begin
      left <= '0;
      dout <= 1'b0;
    end else if (load) begin
      sreg <= result;
      left <= LEN;
      dout <= 1'b0;
    end else if (fall) begin
      if (left != '0) begin
        dout <= sreg[DATA_W-1];
        sreg <= {sreg[DATA_W-2:0], 1'b0};
        left <= left - 1'b1;
      end else begin
        dout <= 1'b0;
      end
    end
  end

  assert_tail_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && left == '0 && !load && !clear) |=> !dout);
endmodule

// File: rtl/serial_adc_port.sv
module serial_adc_port #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [DATA_W-1:0] ch0_code,
  input  logic [DATA_W-1:0] ch1_code,
  output logic              dout,
  output logic              dout_en,
  output logic              sample_win
);
  logic rise, fall, single_ended, sel, load;
  logic [DATA_W-1:0] result;

  sclk_edge_det u_edges (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise(rise), .fall(fall)
  );

  adc_cmd_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(rise), .fall(fall),
    .din(din), .single_ended(single_ended), .sel(sel),
    .sample_win(sample_win), .load(load)
  );

  adc_result_calc #(.DATA_W(DATA_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .single_ended(single_ended), .sel(sel),
    .ch0_code(ch0_code), .ch1_code(ch1_code), .result(result)
  );

  adc_out_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(cs_n), .load(load), .fall(fall),
    .result(result), .dout(dout)
  );

  assign dout_en = !cs_n;

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !fall) |=> $stable(dout));
  assert_idle_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dout);
endmodule

// File: tb/test_serial_adc_port.sv
module test_serial_adc_port;
  localparam int W = 12;
  localparam int HALF = 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [W-1:0] ch0 = '0, ch1 = '0;
  logic dout, dout_en, sample_win;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  serial_adc_port #(.DATA_W(W)) i_serial_adc_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .ch0_code(ch0), .ch1_code(ch1), .dout(dout), .dout_en(dout_en),
    .sample_win(sample_win)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input bit se, input bit s, input int c0, input int c1);
    int p, n, d;
    p = s ? c1 : c0;
    n = s ? c0 : c1;
    if (se) return p;
    d = p - n;
    if (d <= 0) return 0;
    if (d > 4095) return 4095;
    return d;
  endfunction

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  // one sclk period: returns dout before the rise and dout/win during high
  task automatic tick(input bit d, output bit pre_do, output bit pre_w,
                      output bit hi_do, output bit hi_w);
    din = d;
    half_wait();
    pre_do = dout; pre_w = sample_win;
    sclk = 1'b1;
    half_wait();
    hi_do = dout; hi_w = sample_win;
    sclk = 1'b0;
  endtask

  task automatic idle_check();
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 dout_en idle", dout_en, 0);
    chk("R1 dout idle", dout, 0);
    chk("R1 win idle", sample_win, 0);
  endtask

  task automatic conv(input bit se, input bit s, input int c0, input int c1,
                      input int lead, input bit rearm);
    bit pd, pw, hd, hw, last;
    int word;
    string tg;
    ch0 = W'(c0); ch1 = W'(c1);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 dout_en active", dout_en, 1);
    for (int i = 0; i < lead; i++) begin
      tick(1'b0, pd, pw, hd, hw);
      chk("R2 leading zero no window", hw, 0);
    end
    word = 0; last = 1'b0;
    for (int k = 0; k < 19; k++) begin
      bit d;
      d = (k == 0) ? 1'b1 : (k == 1) ? se : (k == 2) ? s : 1'($urandom);
      tick(d, pd, pw, hd, hw);
      if (k == 1) chk("R3 no window at mode bit", hw, 0);
      if (k == 2) begin chk("R4 win low before 2nd rise", pw, 0); chk("R4 win high after 2nd rise", hw, 1); end
      if (k == 3) begin chk("R4 win held low half", pw, 1); chk("R4 win held at 3rd rise", hw, 1); end
      if (k == 4) begin chk("R4 win closed", pw, 0); chk("R5 null bit", pd, 0); end
      if (k >= 5 && k <= 16) word = (word << 1) | int'(pd);
      if (k >= 4) chk("R6 dout steady across rise", hd, pd);
      if (k >= 17) chk("R7 tail low", pd, 0);
      last = hd;
    end
    tg = se ? "R8 single-ended result" : "R9 R10 pseudo-diff result";
    chk(tg, word, exp_code(se, s, c0, c1));
    if (rearm) begin
      for (int k = 0; k < 8; k++) begin
        tick((k < 3) ? 1'b1 : 1'b0, pd, pw, hd, hw);
        chk("R11 no window without cs release", hw | pw, 0);
        chk("R11 dout low without cs release", pd | hd, 0);
      end
    end
    idle_check();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit pd, pw, hd, hw;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1 reset dout", dout, 0);
    chk("R1 reset win", sample_win, 0);
    chk("R1 reset dout_en", dout_en, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    conv(1'b1, 1'b0, 12'hA5C, 12'h123, 0, 1'b0);  // R8 ch0
    conv(1'b1, 1'b1, 12'h0F0, 12'hFFF, 2, 1'b0);  // R8 ch1 all ones
    conv(1'b0, 1'b0, 12'h400, 12'h400, 1, 1'b0);  // R9 equal -> 0
    conv(1'b0, 1'b0, 12'h100, 12'h800, 0, 1'b0);  // R9 negative -> 0
    conv(1'b0, 1'b1, 12'h100, 12'h900, 3, 1'b0);  // R9 ch1 positive
    conv(1'b0, 1'b0, 12'hFFF, 12'h000, 0, 1'b0);  // R10 full scale
    conv(1'b0, 1'b1, 12'h000, 12'hFFF, 1, 1'b0);  // R10 full scale swapped
    conv(1'b1, 1'b0, 12'h3C3, 12'h777, 0, 1'b1);  // R11 rearm needed

    // R12 abort inside sampling window
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    tick(1'b1, pd, pw, hd, hw);
    tick(1'b1, pd, pw, hd, hw);
    tick(1'b0, pd, pw, hd, hw);
    chk("R12 window open before abort", hw, 1);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 abort closes window", sample_win, 0);
    chk("R12 abort disables output", dout_en, 0);
    conv(1'b1, 1'b1, 12'h5A5, 12'h9E1, 1, 1'b0);  // R12 next conversion normal

    for (int t = 0; t < 40; t++) begin
      conv(1'($urandom), 1'($urandom), int'($urandom % 4096), int'($urandom % 4096),
           int'($urandom % 3), 1'b0);
    end

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule